// File: doc/BRIEF.md
# Flash Command and Power-Mode Controller

This block is a cycle-based model of the control front end of a byte-wide parallel flash device. A host drives chip-select, output-enable and write-strobe lines (all active low), an address and a data byte. Bus writes are decoded as commands. These commands choose what a read returns (array contents, identifier bytes or the status byte). They also start block erase, byte program and lock-bit set operations against a small register array held inside the block. Each of these operations is armed by one bus write and launched by a second.

Operation lengths are counted in clock cycles and set by parameters. While an operation runs, reads return status automatically. Deselecting the device only turns off its outputs; the running operation carries on. A low level on the power-down pin does several things. It switches the outputs off and aborts any running operation, leaving the target only partly altered. It resets the command state and the status byte. When the pin returns high, reads stay blocked for a wake-up interval, and commands stay blocked for a longer recovery interval.

The data bus is modelled as a driven value plus a drive-enable: a low enable stands for high impedance.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the device is in array-read mode, every array byte reads 0xFF, and a status read returns 0x80.
- R2: `dout_oe` is high only while `ce_n` and `oe_n` are low and `we_n` is high. When `dout_oe` is low, `dout` is 0x00.
- R3: While `ce_n` or `oe_n` is high, the outputs are off. An operation in progress keeps running while `ce_n` is high.
- R4: The commands 0xFF, 0x90 and 0x70 select array, identifier and status reads. In identifier mode, address bits [1:0] select the returned byte. A value of 0 returns manufacturer code 0xB0. A value of 1 returns device code 0x4C. A value of 2 returns the lock state of the addressed block in bit 0. A value of 3 returns 0x00.
- R5: Writing 0x40 and then a data byte D to address A programs byte A to (old value AND D) after WRITE_CYC cycles. During those cycles status bit 7 (ready) reads 0. When the operation finishes, the read mode is status.
- R6: Writing 0x20 and then 0xD0 to any address in a block sets the block's bytes to 0xFF, lowest offset first, at ERASE_STEP cycles per byte. If the second byte is anything other than 0xD0, status bit 5 is set and no operation starts.
- R7: Writing 0x60 and then 0x01 to an address sets that block's lock bit after WRITE_CYC cycles. Any other second byte sets status bits 5 and 4.
- R8: If `vpp_ok` is low at the second write, the array is left unchanged. Status bit 3 is set, together with bit 4 (program) or bit 5 (erase). If the target block is locked (by lock bit or by `lock_pin`), the array is likewise unchanged. Status bit 1 is set, together with bit 4 or bit 5. Reads work whatever the state of `vpp_ok`.
- R9: Command 0x50 clears status bits 5, 4, 3 and 1.
- R10: Error bits stay set until they are cleared.
- R11: While an operation is running, bus writes are ignored.
- R12: A low `rp_n` turns the outputs off at once. It also aborts a running operation at the next clock edge: bytes already erased stay 0xFF and the rest keep their values. The device stays powered down for at least RP_MIN cycles, even if `rp_n` returns high earlier.
- R13: When power-down ends, the device is in array-read mode with status 0x80. Reads stay off for the first WAKE_CYC cycles. Commands are ignored for the first RECOV_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| rp_n | input | 1 | Power-down / abort pin, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; each cycle low with ce_n low is one bus write |
| addr | input | clog2(NBLK*BLK_BYTES) | Byte address; upper bits select the block |
| din | input | 8 | Command or data byte |
| vpp_ok | input | 1 | Programming supply good |
| lock_pin | input | NBLK | External per-block write protection |
| dout | output | 8 | Read data, 0x00 when not driven |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
The hardest state to reach from the pins is an erase cut off partway through a block. Every earlier byte is already 0xFF, and every later byte still holds data that was programmed deliberately to be different from 0xFF. The bench first fills the block with a computed pattern. It then launches the erase and drops `rp_n` in the cycle just after the second byte has been cleared, a cycle worked out from ERASE_STEP. After waking the device, it reads the whole block back. It also walks through the wake and recovery windows one cycle at a time. In each cycle it checks that reads stay off, and that a command written there does not take effect.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RD_ARRAY,
        CMD_RD_ID,
        CMD_RD_STATUS,
        CMD_CLR_STATUS,
        CMD_ERASE_ARM,
        CMD_ERASE_GO,
        CMD_PROG_ARM,
        CMD_LOCK_ARM,
        CMD_LOCK_GO
    } cmd_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_ID     = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_ERASE_ARM = 3'd1,
        OP_PROG_ARM  = 3'd2,
        OP_LOCK_ARM  = 3'd3,
        OP_ERASE_RUN = 3'd4,
        OP_PROG_RUN  = 3'd5,
        OP_LOCK_RUN  = 3'd6
    } op_state_e;

    typedef enum logic [1:0] {
        PS_ON   = 2'd0,
        PS_DOWN = 2'd1,
        PS_WAKE = 2'd2
    } pwr_state_e;

    localparam logic [7:0] OPC_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OPC_RD_ID     = 8'h90;
    localparam logic [7:0] OPC_RD_STATUS = 8'h70;
    localparam logic [7:0] OPC_CLR       = 8'h50;
    localparam logic [7:0] OPC_ERASE     = 8'h20;
    localparam logic [7:0] OPC_ERASE_OK  = 8'hD0;
    localparam logic [7:0] OPC_PROG      = 8'h40;
    localparam logic [7:0] OPC_LOCK      = 8'h60;
    localparam logic [7:0] OPC_LOCK_OK   = 8'h01;

    localparam int SB_READY = 7;
    localparam int SB_ERASE = 5;
    localparam int SB_PROG  = 4;
    localparam int SB_VOLT  = 3;
    localparam int SB_LOCK  = 1;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_ctrl_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cmd
);

    always_comb begin
        case (code)
            OPC_RD_ARRAY:  cmd = CMD_RD_ARRAY;
            OPC_RD_ID:     cmd = CMD_RD_ID;
            OPC_RD_STATUS: cmd = CMD_RD_STATUS;
            OPC_CLR:       cmd = CMD_CLR_STATUS;
            OPC_ERASE:     cmd = CMD_ERASE_ARM;
            OPC_ERASE_OK:  cmd = CMD_ERASE_GO;
            OPC_PROG:      cmd = CMD_PROG_ARM;
            OPC_LOCK:      cmd = CMD_LOCK_ARM;
            OPC_LOCK_OK:   cmd = CMD_LOCK_GO;
            default:       cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq
    import flash_ctrl_pkg::*;
#(
    parameter int RP_MIN    = 10,
    parameter int WAKE_CYC  = 3,
    parameter int RECOV_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rp_n,
    output logic hold,
    output logic read_ok,
    output logic cmd_ok
);

    localparam int PMAX = (RP_MIN > RECOV_CYC) ? RP_MIN : RECOV_CYC;
    localparam int PW   = $clog2(PMAX + 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [PW-1:0] cnt;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        pwr_d = pwr_q;
        case (pwr_q.st)
            PS_ON: begin
                if (!rp_n) begin
                    pwr_d.st  = PS_DOWN;
                    pwr_d.cnt = '0;
                end
            end
            PS_DOWN: begin
                if (rp_n && (pwr_q.cnt >= PW'(RP_MIN - 1))) begin
                    pwr_d.st  = PS_WAKE;
                    pwr_d.cnt = '0;
                end else if (pwr_q.cnt < PW'(RP_MIN - 1)) begin
                    pwr_d.cnt = pwr_q.cnt + 1'b1;
                end
            end
            PS_WAKE: begin
                if (!rp_n) begin
                    pwr_d.st  = PS_DOWN;
                    pwr_d.cnt = '0;
                end else if (pwr_q.cnt == PW'(RECOV_CYC - 1)) begin
                    pwr_d.st  = PS_ON;
                    pwr_d.cnt = '0;
                end else begin
                    pwr_d.cnt = pwr_q.cnt + 1'b1;
                end
            end
            default: begin
                pwr_d.st  = PS_ON;
                pwr_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= '0;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign hold    = (pwr_q.st != PS_ON);
    assign cmd_ok  = (pwr_q.st == PS_ON);
    assign read_ok = (pwr_q.st == PS_ON) ||
                     ((pwr_q.st == PS_WAKE) && (pwr_q.cnt >= PW'(WAKE_CYC)));

endmodule

// File: rtl/flash_op_core.sv
module flash_op_core
    import flash_ctrl_pkg::*;
#(
    parameter int           NBLK       = 4,
    parameter int           BLK_BYTES  = 8,
    parameter int           ERASE_STEP = 3,
    parameter int           WRITE_CYC  = 4,
    parameter logic [7:0]   MFR_ID     = 8'hB0,
    parameter logic [7:0]   DEV_ID     = 8'h4C
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                hold,
    input  logic                                wr_stb,
    input  logic [$clog2(NBLK*BLK_BYTES)-1:0]   addr,
    input  logic [7:0]                          din,
    input  logic                                vpp_ok,
    input  logic [NBLK-1:0]                     lock_pin,
    output logic [7:0]                          rd_data,
    output logic                                busy
);

    localparam int NBYTES = NBLK * BLK_BYTES;
    localparam int AW     = $clog2(NBYTES);
    localparam int OW     = $clog2(BLK_BYTES);
    localparam int CMAX   = (ERASE_STEP > WRITE_CYC) ? ERASE_STEP : WRITE_CYC;
    localparam int CW     = $clog2(CMAX + 1);

    typedef struct packed {
        op_state_e                 st;
        rd_mode_e                  rdm;
        logic                      e_erase;
        logic                      e_prog;
        logic                      e_volt;
        logic                      e_lock;
        logic [CW-1:0]             cnt;
        logic [OW-1:0]             idx;
        logic [AW-1:0]             tgt;
        logic [7:0]                wdat;
        logic [NBLK-1:0]           lock;
        logic [NBYTES-1:0][7:0]    mem;
    } core_t;

    core_t core_d, core_q, core_rst;
    cmd_e  cmd;

    logic [AW-OW-1:0] blk_sel;
    logic [AW-OW-1:0] tgt_blk;
    logic [NBLK-1:0]  lock_eff;
    logic             running;
    logic [7:0]       stat_byte;

    flash_cmd_decode u_dec (
        .code (din),
        .cmd  (cmd)
    );

    assign blk_sel  = addr[AW-1:OW];
    assign tgt_blk  = core_q.tgt[AW-1:OW];
    assign lock_eff = core_q.lock | lock_pin;
    assign running  = (core_q.st == OP_ERASE_RUN) ||
                      (core_q.st == OP_PROG_RUN)  ||
                      (core_q.st == OP_LOCK_RUN);

    always_comb begin
        core_rst     = '0;
        core_rst.st  = OP_IDLE;
        core_rst.rdm = RD_ARRAY;
        core_rst.mem = {NBYTES{8'hFF}};
    end

    always_comb begin
        core_d = core_q;
        case (core_q.st)
            OP_IDLE: begin
                if (wr_stb) begin
                    case (cmd)
                        CMD_RD_ARRAY:  core_d.rdm = RD_ARRAY;
                        CMD_RD_ID:     core_d.rdm = RD_ID;
                        CMD_RD_STATUS: core_d.rdm = RD_STATUS;
                        CMD_CLR_STATUS: begin
                            core_d.e_erase = 1'b0;
                            core_d.e_prog  = 1'b0;
                            core_d.e_volt  = 1'b0;
                            core_d.e_lock  = 1'b0;
                        end
                        CMD_ERASE_ARM: begin
                            core_d.st  = OP_ERASE_ARM;
                            core_d.rdm = RD_STATUS;
                        end
                        CMD_PROG_ARM: begin
                            core_d.st  = OP_PROG_ARM;
                            core_d.rdm = RD_STATUS;
                        end
                        CMD_LOCK_ARM: begin
                            core_d.st  = OP_LOCK_ARM;
                            core_d.rdm = RD_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            OP_ERASE_ARM: begin
                if (wr_stb) begin
                    core_d.st = OP_IDLE;
                    if (cmd != CMD_ERASE_GO) begin
                        core_d.e_erase = 1'b1;
                    end else if (!vpp_ok) begin
                        core_d.e_erase = 1'b1;
                        core_d.e_volt  = 1'b1;
                    end else if (lock_eff[blk_sel]) begin
                        core_d.e_erase = 1'b1;
                        core_d.e_lock  = 1'b1;
                    end else begin
                        core_d.st  = OP_ERASE_RUN;
                        core_d.tgt = addr;
                        core_d.idx = '0;
                        core_d.cnt = '0;
                    end
                end
            end
            OP_PROG_ARM: begin
                if (wr_stb) begin
                    core_d.st = OP_IDLE;
                    if (!vpp_ok) begin
                        core_d.e_prog = 1'b1;
                        core_d.e_volt = 1'b1;
                    end else if (lock_eff[blk_sel]) begin
                        core_d.e_prog = 1'b1;
                        core_d.e_lock = 1'b1;
                    end else begin
                        core_d.st   = OP_PROG_RUN;
                        core_d.tgt  = addr;
                        core_d.wdat = din;
                        core_d.cnt  = '0;
                    end
                end
            end
            OP_LOCK_ARM: begin
                if (wr_stb) begin
                    core_d.st = OP_IDLE;
                    if (cmd != CMD_LOCK_GO) begin
                        core_d.e_erase = 1'b1;
                        core_d.e_prog  = 1'b1;
                    end else if (!vpp_ok) begin
                        core_d.e_prog = 1'b1;
                        core_d.e_volt = 1'b1;
                    end else begin
                        core_d.st  = OP_LOCK_RUN;
                        core_d.tgt = addr;
                        core_d.cnt = '0;
                    end
                end
            end
            OP_ERASE_RUN: begin
                if (core_q.cnt == CW'(ERASE_STEP - 1)) begin
                    core_d.cnt = '0;
                    core_d.mem[{tgt_blk, core_q.idx}] = 8'hFF;
                    if (core_q.idx == OW'(BLK_BYTES - 1)) begin
                        core_d.st = OP_IDLE;
                    end else begin
                        core_d.idx = core_q.idx + 1'b1;
                    end
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            OP_PROG_RUN: begin
                if (core_q.cnt == CW'(WRITE_CYC - 1)) begin
                    core_d.mem[core_q.tgt] = core_q.mem[core_q.tgt] & core_q.wdat;
                    core_d.st = OP_IDLE;
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            OP_LOCK_RUN: begin
                if (core_q.cnt == CW'(WRITE_CYC - 1)) begin
                    core_d.lock[tgt_blk] = 1'b1;
                    core_d.st = OP_IDLE;
                end else begin
                    core_d.cnt = core_q.cnt + 1'b1;
                end
            end
            default: core_d.st = OP_IDLE;
        endcase

        if (hold) begin
            core_d.st      = OP_IDLE;
            core_d.rdm     = RD_ARRAY;
            core_d.e_erase = 1'b0;
            core_d.e_prog  = 1'b0;
            core_d.e_volt  = 1'b0;
            core_d.e_lock  = 1'b0;
            core_d.cnt     = '0;
            core_d.idx     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= core_rst;
        end else begin
            core_q <= core_d;
        end
    end

    always_comb begin
        stat_byte           = 8'h00;
        stat_byte[SB_READY] = !running;
        stat_byte[SB_ERASE] = core_q.e_erase;
        stat_byte[SB_PROG]  = core_q.e_prog;
        stat_byte[SB_VOLT]  = core_q.e_volt;
        stat_byte[SB_LOCK]  = core_q.e_lock;
    end

    always_comb begin
        case (core_q.rdm)
            RD_ARRAY:  rd_data = core_q.mem[addr];
            RD_STATUS: rd_data = stat_byte;
            RD_ID: begin
                case (addr[1:0])
                    2'd0:    rd_data = MFR_ID;
                    2'd1:    rd_data = DEV_ID;
                    2'd2:    rd_data = {7'd0, lock_eff[blk_sel]};
                    default: rd_data = 8'h00;
                endcase
            end
            default:   rd_data = stat_byte;
        endcase
    end

    assign busy = running;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int         NBLK       = 4,
    parameter int         BLK_BYTES  = 8,
    parameter int         ERASE_STEP = 3,
    parameter int         WRITE_CYC  = 4,
    parameter int         RP_MIN     = 10,
    parameter int         WAKE_CYC   = 3,
    parameter int         RECOV_CYC  = 5,
    parameter logic [7:0] MFR_ID     = 8'hB0,
    parameter logic [7:0] DEV_ID     = 8'h4C
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rp_n,
    input  logic                              ce_n,
    input  logic                              oe_n,
    input  logic                              we_n,
    input  logic [$clog2(NBLK*BLK_BYTES)-1:0] addr,
    input  logic [7:0]                        din,
    input  logic                              vpp_ok,
    input  logic [NBLK-1:0]                   lock_pin,
    output logic [7:0]                        dout,
    output logic                              dout_oe
);

    logic pd_hold;
    logic rd_ok;
    logic cmd_ok;
    logic core_hold;
    logic wr_stb;
    logic op_busy;
    logic [7:0] core_data;

    flash_pwr_seq #(
        .RP_MIN    (RP_MIN),
        .WAKE_CYC  (WAKE_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rp_n    (rp_n),
        .hold    (pd_hold),
        .read_ok (rd_ok),
        .cmd_ok  (cmd_ok)
    );

    assign core_hold = pd_hold || !rp_n;
    assign wr_stb    = !ce_n && !we_n && cmd_ok && rp_n;

    flash_op_core #(
        .NBLK       (NBLK),
        .BLK_BYTES  (BLK_BYTES),
        .ERASE_STEP (ERASE_STEP),
        .WRITE_CYC  (WRITE_CYC),
        .MFR_ID     (MFR_ID),
        .DEV_ID     (DEV_ID)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (core_hold),
        .wr_stb   (wr_stb),
        .addr     (addr),
        .din      (din),
        .vpp_ok   (vpp_ok),
        .lock_pin (lock_pin),
        .rd_data  (core_data),
        .busy     (op_busy)
    );

    assign dout_oe = !ce_n && !oe_n && we_n && rp_n && rd_ok;
    assign dout    = dout_oe ? core_data : 8'h00;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
    input logic clk,
    input logic rst_n,
    input logic rp_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic dout_oe,
    input logic busy,
    input logic read_ok,
    input logic cmd_ok
);

    // R3
    ce_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !dout_oe);

    // R2
    write_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_oe);

    // R12
    pd_output_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> !dout_oe);

    // R12
    pd_abort_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> !busy);

    // R13
    recov_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |-> read_ok);

    // R13
    pd_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> !cmd_ok);

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rp_n    (rp_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .dout_oe (dout_oe),
    .busy    (op_busy),
    .read_ok (rd_ok),
    .cmd_ok  (cmd_ok)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;

    localparam int NBLK = 4, BLK_BYTES = 8, NBYTES = 32;
    localparam int ES = 3, WC = 4, RPM = 10, WAKE = 3, RECOV = 5;

    logic clk = 1'b0;
    logic rst_n, rp_n, ce_n, oe_n, we_n, vpp_ok;
    logic [4:0] addr;
    logic [7:0] din;
    logic [NBLK-1:0] lock_pin;
    logic [7:0] dout;
    logic dout_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] exp_mem [NBYTES];
    logic [7:0] rd_d;
    logic rd_o;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(
        .NBLK(NBLK), .BLK_BYTES(BLK_BYTES), .ERASE_STEP(ES), .WRITE_CYC(WC),
        .RP_MIN(RPM), .WAKE_CYC(WAKE), .RECOV_CYC(RECOV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .din(din), .vpp_ok(vpp_ok),
        .lock_pin(lock_pin), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [4:0] a);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #2;
        rd_d = dout; rd_o = dout_oe;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; rp_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        vpp_ok = 1'b1; lock_pin = '0; addr = '0; din = '0;
        for (int i = 0; i < NBYTES; i++) exp_mem[i] = 8'hFF;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1: erased array, array mode, status 0x80
        bus_rd(5); chk8("R1 array", rd_d, 8'hFF); chk8("R1 oe", {7'd0, rd_o}, 8'h01);
        bus_wr(0, 8'h70); bus_rd(0); chk8("R1 status", rd_d, 8'h80);
        bus_wr(0, 8'hFF);

        // R2 R3: sweep of strobe combinations
        for (int m = 0; m < 8; m++) begin
            ce_n = m[0]; oe_n = m[1]; we_n = m[2]; addr = 5'd3; din = 8'hFF;
            #2;
            chk8("R2 R3 oe", {7'd0, dout_oe}, (m == 4) ? 8'h01 : 8'h00);
            chk8("R2 R3 dout", dout, (m == 4) ? 8'hFF : 8'h00);
            @(negedge clk);
            ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        end

        // R4: identifier reads
        bus_wr(0, 8'h90);
        bus_rd(0);  chk8("R4 mfr", rd_d, 8'hB0);
        bus_rd(1);  chk8("R4 dev", rd_d, 8'h4C);
        bus_rd(10); chk8("R4 lock0", rd_d, 8'h00);
        bus_rd(11); chk8("R4 addr3", rd_d, 8'h00);
        lock_pin = 4'b0010;
        bus_rd(10); chk8("R4 lockpin", rd_d, 8'h01);
        lock_pin = '0;

        // R5: two programming passes over every byte
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < NBYTES; a++) begin
                logic [7:0] d;
                d = (p == 0) ? 8'(a * 29 + 5) : ~8'(a * 13);
                bus_wr(5'(a), 8'h40);
                bus_wr(5'(a), d);
                exp_mem[a] = exp_mem[a] & d;
                if (p == 0 && a == 0) begin
                    idle(WC - 1);
                    bus_rd(0); chk8("R5 busy status", rd_d, 8'h00);
                    bus_rd(0); chk8("R5 ready status", rd_d, 8'h80);
                end else if (p == 0 && a == 1) begin
                    // R11: read-array command during busy ignored
                    bus_wr(0, 8'hFF);
                    idle(WC - 1);
                    bus_rd(0); chk8("R11 still status", rd_d, 8'h80);
                end else if (p == 0 && a == 2) begin
                    // R3: deselected during busy, outputs off, op completes
                    ce_n = 1'b1; oe_n = 1'b0; #2;
                    chk8("R3 standby oe", {7'd0, dout_oe}, 8'h00);
                    oe_n = 1'b1;
                    idle(WC);
                end else begin
                    idle(WC);
                end
            end
            bus_wr(0, 8'hFF);
            for (int a = 0; a < NBYTES; a++) begin
                bus_rd(5'(a)); chk8("R5 array", rd_d, exp_mem[a]);
            end
        end

        // R6: erase every block, check all bytes
        for (int b = 0; b < NBLK; b++) begin
            bus_wr(5'(b * 8 + 1), 8'h20);
            bus_wr(5'(b * 8 + ((b * 3) % 8)), 8'hD0);
            if (b == 0) begin
                idle(BLK_BYTES * ES - 1);
                bus_rd(0); chk8("R6 busy", rd_d, 8'h00);
                bus_rd(0); chk8("R6 done", rd_d, 8'h80);
            end else begin
                idle(BLK_BYTES * ES);
            end
            for (int i = 0; i < BLK_BYTES; i++) exp_mem[b * 8 + i] = 8'hFF;
            bus_wr(0, 8'hFF);
            for (int a = 0; a < NBYTES; a++) begin
                bus_rd(5'(a)); chk8("R6 array", rd_d, exp_mem[a]);
            end
        end

        // refill blocks 1 and 2
        for (int a = 8; a < 24; a++) begin
            bus_wr(5'(a), 8'h40);
            bus_wr(5'(a), 8'(a * 7 + 1));
            exp_mem[a] = 8'(a * 7 + 1);
            idle(WC);
        end

        // R6 R10 R9: mismatched erase confirm, sticky until cleared
        bus_wr(0, 8'h20); bus_wr(0, 8'hAA);
        bus_rd(0); chk8("R6 bad confirm", rd_d, 8'hA0);
        idle(3);
        bus_rd(0); chk8("R10 sticky", rd_d, 8'hA0);
        bus_wr(0, 8'h50); bus_rd(0); chk8("R9 clear", rd_d, 8'h80);

        // R8: low programming voltage
        vpp_ok = 1'b0;
        bus_wr(9, 8'h40); bus_wr(9, 8'h00);
        bus_rd(0); chk8("R8 volt status", rd_d, 8'h98);
        idle(WC + 1);
        bus_wr(0, 8'hFF);
        bus_rd(9); chk8("R8 volt array", rd_d, exp_mem[9]);
        chk8("R8 read with low volt", {7'd0, rd_o}, 8'h01);
        vpp_ok = 1'b1;
        bus_wr(0, 8'h50);

        // R8: locked via pin
        lock_pin = 4'b0010;
        bus_wr(8, 8'h20); bus_wr(8, 8'hD0);
        bus_rd(0); chk8("R8 lock status", rd_d, 8'hA2);
        idle(BLK_BYTES * ES + 1);
        bus_wr(0, 8'hFF);
        bus_rd(8); chk8("R8 lock array", rd_d, exp_mem[8]);
        lock_pin = '0;
        bus_wr(0, 8'h50);

        // R7: lock-bit set on block 2
        bus_wr(16, 8'h60); bus_wr(17, 8'h01);
        idle(WC);
        bus_rd(0); chk8("R7 lock done", rd_d, 8'h80);
        bus_wr(0, 8'h90);
        bus_rd(18); chk8("R7 lock id", rd_d, 8'h01);
        bus_rd(10); chk8("R7 other block", rd_d, 8'h00);
        bus_wr(20, 8'h40); bus_wr(20, 8'h00);
        bus_rd(0); chk8("R7 R8 locked prog", rd_d, 8'h92);
        bus_wr(0, 8'hFF);
        bus_rd(20); chk8("R7 array kept", rd_d, exp_mem[20]);
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h60); bus_wr(0, 8'h33);
        bus_rd(0); chk8("R7 bad confirm", rd_d, 8'hB0);
        bus_wr(0, 8'h50);

        // R12: abort an erase of block 1 after two bytes
        bus_wr(8, 8'h20); bus_wr(8, 8'hD0);
        idle(2 * ES);
        rp_n = 1'b0;
        bus_rd(8); chk8("R12 pd oe", {7'd0, rd_o}, 8'h00);
        idle(RPM + 1);
        rp_n = 1'b1;
        idle(1);
        // R13: wake window walked cycle by cycle
        bus_rd(10); chk8("R13 wake cnt0", {7'd0, rd_o}, 8'h00);
        bus_wr(0, 8'h90);
        bus_rd(10); chk8("R13 wake cnt2", {7'd0, rd_o}, 8'h00);
        bus_rd(10); chk8("R13 wake cnt3", {7'd0, rd_o}, 8'h01);
        bus_wr(0, 8'h90);
        bus_rd(10); chk8("R13 cmds ignored", rd_d, exp_mem[10]);
        exp_mem[8] = 8'hFF; exp_mem[9] = 8'hFF;
        for (int a = 8; a < 16; a++) begin
            bus_rd(5'(a)); chk8("R12 partial erase", rd_d, exp_mem[a]);
        end
        bus_wr(0, 8'h90);
        bus_rd(0); chk8("R13 cmd accepted", rd_d, 8'hB0);
        bus_wr(0, 8'h70);
        bus_rd(0); chk8("R13 status", rd_d, 8'h80);

        // R12 R13: short pulse stretched to RP_MIN, errors cleared
        bus_wr(0, 8'h20); bus_wr(0, 8'h00);
        bus_rd(0); chk8("R6 pre-pulse err", rd_d, 8'hA0);
        rp_n = 1'b0; idle(2); rp_n = 1'b1;
        idle(3);
        bus_rd(0); chk8("R12 min low", {7'd0, rd_o}, 8'h00);
        idle(RPM + RECOV + 2);
        bus_rd(3); chk8("R13 array mode", rd_d, exp_mem[3]);
        bus_wr(0, 8'h70);
        bus_rd(0); chk8("R13 status reset", rd_d, 8'h80);

        done = 1;
        finish_run();
    end

endmodule